// File: doc/BRIEF.md
# Dual Programmable Blink Clock Generator

This block produces slow square waves for blinking LEDs or for other low-rate clock uses on general-purpose pins. It holds a set of independent generators, two by default. Each one drives a single output level whose high and low phases are programmed separately. Each phase length is a 7-bit count of a base period, and the base period is picked by a 2-bit select from four periods spaced by factors of eight. At the default prescaler setting those periods are 250 µs, 2 ms, 16 ms and 128 ms. Across the four bases a phase can therefore last anywhere from one quarter of a millisecond to roughly sixteen seconds.

All generators share one prescaler chain. Its first stage divides the system clock by a parameter. Each further stage divides the previous tick by eight, so every coarser tick falls on a tick of the next finer base. A generator takes its phase length and base select only when a phase starts. Software may therefore rewrite these inputs at any time without cutting a phase short or stretching it.

Top module: `blink_clock_pair`

## Requirements
- R1: Each generator runs from its own select and phase-length inputs only. Any configuration of one generator leaves the phase lengths of the other unchanged.
- R2: For a phase-length value N in 1..127, the high phase lasts N base periods when N is on the high-time input, and the low phase lasts N base periods when N is on the low-time input.
- R3: A phase-length value of 0 gives a phase of 128 base periods.
- R4: Base select value s (0..3) gives a base period of TICK_DIV·8^s system clock cycles. The output changes level only in a cycle that follows a base tick.
- R5: While reset is applied and in the first cycle after reset, every output is low. The first phase after reset is a low phase, so the first output change is a rise.
- R6: A change to the high-time or low-time input made during a phase leaves that phase's length unchanged. The new value is used the next time a phase of that kind starts.
- R7: A change to the base select made during a phase leaves that phase's length unchanged. The new base applies from the next phase boundary.
- R8: Each base tick of the prescaler coincides with a tick of the next finer base. Ticks of base 1 and coarser never occur in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| base_sel | input | NGEN×SEL_W (2×2) | Base-period select per generator, 0 = finest |
| high_time | input | NGEN×CNT_W (2×7) | High phase length per generator in base periods, 0 = 128 |
| low_time | input | NGEN×CNT_W (2×7) | Low phase length per generator in base periods, 0 = 128 |
| blink_o | output | NGEN (2) | Square-wave output per generator |

## Verification
The bench builds the block with TICK_DIV = 1. Base periods then become 1, 8, 64 and 512 clock cycles. At that setting every base select, every phase length from 1 to 128 periods, and reconfiguration at a chosen point inside a phase all fit in a short run. Expected phase lengths are computed as N·8^s cycles, where a value of 0 stands for 128. They are compared against the measured distance between output edges on both generators.

// File: rtl/blink_pkg.sv
package blink_pkg;
  // log2 of the ratio between neighbouring base periods
  localparam int STAGE_LOG2 = 3;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;
endpackage

// File: rtl/blink_rst_sync.sv
module blink_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/blink_prescaler.sv
module blink_prescaler
  import blink_pkg::*;
#(
  parameter int TICK_DIV = 12500,
  parameter int NBASE    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [NBASE-1:0] tick
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  // first stage: system clock down to the finest base tick
  generate
    if (TICK_DIV == 1) begin : g_pass
      assign tick[0] = 1'b1;
    end else begin : g_div
      localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
      logic [PW-1:0] pre_q;
      logic [PW-1:0] pre_d;
      logic          wrap;

      assign wrap = (pre_q == LAST);

      always_comb begin
        pre_d = wrap ? '0 : pre_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
      end

      assign tick[0] = wrap;
    end
  endgenerate

  // divide-by-eight stages, each clock-enabled by the finer tick
  generate
    for (genvar k = 1; k < NBASE; k++) begin : g_stage
      logic [STAGE_LOG2-1:0] stg_q;
      logic [STAGE_LOG2-1:0] stg_d;
      logic                  stg_en;

      assign stg_en = tick[k-1];

      always_comb begin
        stg_d = stg_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      stg_q <= '0;
        else if (stg_en) stg_q <= stg_d;
      end

      assign tick[k] = tick[k-1] & (&stg_q);
    end
  endgenerate
endmodule

// File: rtl/blink_phase_gen.sv
module blink_phase_gen
  import blink_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int NBASE = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBASE-1:0] tick,
  input  logic [SEL_W-1:0] base_sel,
  input  logic [CNT_W-1:0] high_time,
  input  logic [CNT_W-1:0] low_time,
  output logic             blink
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  phase_e           phase_q, phase_d;
  logic             arm_q, arm_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] dur_q, dur_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [CNT_W-1:0] dur_m1;
  logic             tick_sel;
  logic             last_tick;
  logic             adv_en;

  assign tick_sel  = tick[sel_q];
  assign dur_m1    = dur_q - ONE;      // value 0 wraps to 2^CNT_W - 1
  assign last_tick = tick_sel && (cnt_q == dur_m1);
  assign adv_en    = arm_q | tick_sel;

  always_comb begin
    phase_d = phase_q;
    arm_d   = arm_q;
    cnt_d   = cnt_q;
    dur_d   = dur_q;
    sel_d   = sel_q;
    if (arm_q) begin
      arm_d = 1'b0;
      cnt_d = '0;
      dur_d = low_time;
      sel_d = base_sel;
    end else if (last_tick) begin
      cnt_d = '0;
      sel_d = base_sel;
      if (phase_q == PH_LOW) begin
        phase_d = PH_HIGH;
        dur_d   = high_time;
      end else begin
        phase_d = PH_LOW;
        dur_d   = low_time;
      end
    end else begin
      cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_LOW;
      arm_q   <= 1'b1;
      cnt_q   <= '0;
      dur_q   <= '0;
      sel_q   <= '0;
    end else if (adv_en) begin
      phase_q <= phase_d;
      arm_q   <= arm_d;
      cnt_q   <= cnt_d;
      dur_q   <= dur_d;
      sel_q   <= sel_d;
    end
  end

  assign blink = (phase_q == PH_HIGH);
endmodule

// File: rtl/blink_clock_pair.sv
module blink_clock_pair #(
  parameter int TICK_DIV = 12500,
  parameter int NGEN     = 2,
  parameter int CNT_W    = 7,
  parameter int NBASE    = 4,
  parameter int SEL_W    = (NBASE > 1) ? $clog2(NBASE) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NGEN-1:0][SEL_W-1:0]  base_sel,
  input  logic [NGEN-1:0][CNT_W-1:0]  high_time,
  input  logic [NGEN-1:0][CNT_W-1:0]  low_time,
  output logic [NGEN-1:0]             blink_o
);
  logic             rst_sync_n;
  logic [NBASE-1:0] base_tick;

  blink_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  blink_prescaler #(
    .TICK_DIV (TICK_DIV),
    .NBASE    (NBASE)
  ) u_pre (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (base_tick)
  );

  generate
    for (genvar g = 0; g < NGEN; g++) begin : g_gen
      blink_phase_gen #(
        .CNT_W (CNT_W),
        .NBASE (NBASE),
        .SEL_W (SEL_W)
      ) u_phase (
        .clk       (clk),
        .rst_n     (rst_sync_n),
        .tick      (base_tick),
        .base_sel  (base_sel[g]),
        .high_time (high_time[g]),
        .low_time  (low_time[g]),
        .blink     (blink_o[g])
      );
    end
  endgenerate
endmodule

// File: rtl/blink_checker.sv
module blink_checker #(
  parameter int NGEN  = 2,
  parameter int NBASE = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NBASE-1:0] tick,
  input logic [NGEN-1:0]  blink
);
  generate
    for (genvar k = 1; k < NBASE; k++) begin : g_tick
      // R8: a coarse tick always lands on a finer tick
      p_tick_nested_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick[k] |-> tick[k-1]);
      // R8: coarse ticks are at least eight cycles apart, never back to back
      p_tick_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick[k] |=> !tick[k]);
    end
    for (genvar g = 0; g < NGEN; g++) begin : g_out
      // R4: an output only changes after a base tick
      p_toggle_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (blink[g] != $past(blink[g])) |-> $past(tick[0]));
    end
  endgenerate

  // R5: outputs are low when reset has just been released
  p_reset_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (blink == '0));
endmodule

bind blink_clock_pair blink_checker #(
  .NGEN  (NGEN),
  .NBASE (NBASE)
) u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .tick  (base_tick),
  .blink (blink_o)
);

// File: tb/tb_blink_clock_pair.sv
module tb_blink_clock_pair;
  localparam int CLK_PERIOD = 10;
  localparam int NGEN  = 2;
  localparam int CNT_W = 7;
  localparam int NBASE = 4;
  localparam int SEL_W = 2;

  logic                       clk = 1'b0;
  logic                       rst_n = 1'b1;
  logic [NGEN-1:0][SEL_W-1:0] base_sel;
  logic [NGEN-1:0][CNT_W-1:0] high_time;
  logic [NGEN-1:0][CNT_W-1:0] low_time;
  logic [NGEN-1:0]            blink_o;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  blink_clock_pair #(
    .TICK_DIV (1),
    .NGEN     (NGEN),
    .CNT_W    (CNT_W),
    .NBASE    (NBASE)
  ) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .base_sel  (base_sel),
    .high_time (high_time),
    .low_time  (low_time),
    .blink_o   (blink_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int plen(input int n, input int s);
    return ((n == 0) ? 128 : n) * (1 << (3 * s));
  endfunction

  task automatic wait_tog(input int g, output int t);
    logic prev;
    prev = blink_o[g];
    do @(negedge clk); while (blink_o[g] == prev);
    t = cyc;
  endtask

  task automatic setup(input int g, input int s, input int hi, input int lo);
    @(negedge clk);
    base_sel[g]  = SEL_W'(s);
    high_time[g] = CNT_W'(hi);
    low_time[g]  = CNT_W'(lo);
  endtask

  task automatic settle(input int g);
    int t;
    for (int i = 0; i < 3; i++) wait_tog(g, t);
  endtask

  task automatic measure(input int g, input int s, input int hi, input int lo,
                         input string req);
    int t1, t2, t3;
    logic lvl;
    wait_tog(g, t1);
    lvl = blink_o[g];
    wait_tog(g, t2);
    wait_tog(g, t3);
    check((t2 - t1) == plen(lvl ? hi : lo, s), req, lvl ? "high phase" : "low phase",
          t2 - t1, plen(lvl ? hi : lo, s));
    check((t3 - t2) == plen(lvl ? lo : hi, s), req, lvl ? "low phase" : "high phase",
          t3 - t2, plen(lvl ? lo : hi, s));
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual %0d expected 0", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int tr, tf, t;
    base_sel[0] = 2'd0; high_time[0] = 7'd3; low_time[0] = 7'd5;
    base_sel[1] = 2'd1; high_time[1] = 7'd2; low_time[1] = 7'd1;
    #1 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R5: low during reset
    check(blink_o == '0, "R5", "outputs in reset", int'(blink_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(blink_o == '0, "R5", "outputs after release", int'(blink_o), 0);
    wait_tog(0, t);
    // R5: first change is a rise
    check(blink_o[0] == 1'b1, "R5", "first edge level", int'(blink_o[0]), 1);

    // R2, R1: both generators with their reset-time settings
    measure(0, 0, 3, 5, "R2");
    measure(1, 1, 2, 1, "R1");

    // R2, R3, R4, R8: sweep of lengths at each base on generator 0
    for (int n = 0; n < 128; n += 9) begin
      setup(0, 0, n, 127 - n);
      settle(0);
      measure(0, 0, n, 127 - n, (n == 0) ? "R3" : "R2");
    end
    setup(0, 0, 127, 1); settle(0); measure(0, 0, 127, 1, "R2");
    setup(0, 0, 0, 0);   settle(0); measure(0, 0, 0, 0, "R3");
    setup(0, 1, 1, 3);   settle(0); measure(0, 1, 1, 3, "R4");
    setup(0, 1, 0, 2);   settle(0); measure(0, 1, 0, 2, "R3");
    setup(0, 2, 1, 2);   settle(0); measure(0, 2, 1, 2, "R4");
    setup(0, 3, 2, 1);   settle(0); measure(0, 3, 2, 1, "R8");

    // R1: generator 1 at other settings while generator 0 runs differently
    setup(0, 0, 2, 2);
    setup(1, 2, 1, 3);
    settle(1); measure(1, 2, 1, 3, "R1");
    settle(0); measure(0, 0, 2, 2, "R1");
    setup(1, 0, 7, 4);
    settle(1); measure(1, 0, 7, 4, "R1");

    // R6: high time rewritten at the start of a high phase
    setup(0, 0, 5, 5); settle(0);
    do wait_tog(0, tr); while (blink_o[0] != 1'b1);
    high_time[0] = 7'd9;
    wait_tog(0, tf);
    check((tf - tr) == 5, "R6", "current high kept", tf - tr, 5);
    wait_tog(0, tr);
    check((tr - tf) == 5, "R6", "low after change", tr - tf, 5);
    wait_tog(0, tf);
    check((tf - tr) == 9, "R6", "next high new", tf - tr, 9);

    // R7: base select rewritten at the start of a high phase
    setup(0, 0, 4, 4); settle(0);
    do wait_tog(0, tr); while (blink_o[0] != 1'b1);
    base_sel[0] = 2'd1;
    wait_tog(0, tf);
    check((tf - tr) == 4, "R7", "current high kept", tf - tr, 4);
    settle(0);
    measure(0, 1, 4, 4, "R7");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule